// File: doc/BRIEF.md
# MDIO Management Command Engine

This block runs IEEE 802.3 clause 22 management transactions toward an external PHY. Software controls it through a single 32-bit command word. The word holds the operation, the PHY address, the PHY register address and a 16-bit data field. Setting the busy/start bit in an accepted write launches a frame. The engine then shifts the frame out on MDC/MDIO. When the frame ends, the engine clears the busy bit by itself.

After a read, the data field holds the value the PHY returned. If the PHY never claims the bus during turnaround, a failure flag is set instead. On every completion the engine emits a one-cycle done pulse for an interrupt controller. A failed read also emits an error pulse.

MDC is derived from the system clock through a programmable half-period. The frame has a 32-bit preamble of ones, the start code 01, the opcode, both addresses, a two-bit turnaround and sixteen data bits, all sent MSB first.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command word reads zero, MDC is low, MDIO is not driven, and neither pulse output is high.
- R2: The command word layout is: bit 29 busy/start, bit 28 read-fail, bits 27:26 operation (2 = read, 1 = write), bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. Bits 31:30 always read zero.
- R3: An accepted write with bit 29 set launches a frame. Busy reads 1 from the next cycle until completion and then clears by itself. An accepted write with bit 29 clear only stores the fields.
- R4: Writes that arrive while busy reads 1 are ignored and leave every field unchanged.
- R5: The frame is 32 ones, 01, the two opcode bits, PHY address, register address, turnaround, then the data, MSB first. On a write the engine drives the turnaround as 10 and then the data field.
- R6: On a read, MDIO is released (output enable low) from the first turnaround bit until the end of the frame.
- R7: On a read whose second turnaround bit is sampled low, the 16 sampled bits replace bits 15:0 and the fail flag stays 0. Otherwise bit 28 is set and bits 15:0 keep their earlier value.
- R8: Every completion gives a one-cycle done pulse in the cycle busy first reads 0. A failed read gives an error pulse in that same cycle.
- R9: MDC is low when idle. Each MDC half-period lasts mdcHalf+1 system clocks. MDIO output changes only when MDC falls, and input is sampled when MDC rises.
- R10: Launching a frame clears the read-fail flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command word write strobe |
| cmdWrData | input | 32 | Command word write value |
| cmdRdData | output | 32 | Command word read value |
| mdcHalf | input | 8 | MDC half-period minus one, in system clocks |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input from the pad |
| doneIrq | output | 1 | One-cycle completion pulse |
| errIrq | output | 1 | One-cycle read-failure pulse |

## Verification
The end of a frame and a software write can fall in the same cycle. The write reaches the edge at which busy drops, and because busy is still set it must be discarded. The bench provokes this by holding the write strobe high with a different command through the last bit of a read. In the cycle the done pulse shows, it expects the word to hold the read result with busy clear. One cycle later it expects the new fields, which proves the write was taken only once busy had fallen.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FRAME_LEN    = 64;
  localparam int PREAMBLE_LEN = 32;
  localparam int IDX_W        = $clog2(FRAME_LEN);
  localparam int TA_FIRST     = 46;
  localparam int TA_SECOND    = 47;
  localparam int DATA_FIRST   = 48;
  localparam int BIT_BUSY     = 29;
  localparam int BIT_FAIL     = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef struct packed {
    logic launch;
    logic sampleEdge;
    logic shiftEdge;
    logic finish;
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
`timescale 1ns/1ps
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [DIV_W-1:0]   mdcHalf,
  output logic               busy,
  output logic               mdc,
  output logic [IDX_W-1:0]   bitIdx,
  output mdioStrobes_t       strobes
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [DIV_W-1:0] divCnt;
  logic tick;

  assign tick = busy && (divCnt >= mdcHalf);

  always_comb begin
    strobes.launch     = startReq && !busy;
    strobes.sampleEdge = tick && !mdc;
    strobes.shiftEdge  = tick && mdc && (bitIdx != LAST_IDX);
    strobes.finish     = tick && mdc && (bitIdx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (strobes.launch) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        mdc    <= ~mdc;
        if (strobes.shiftEdge) bitIdx <= bitIdx + 1'b1;
        if (strobes.finish) begin
          busy   <= 1'b0;
          bitIdx <= '0;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assert_finish_clears_busy_R3 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> !busy);

  assert_idle_mdc_low_R9 : assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
endmodule

// File: rtl/mdio_datapath.sv
`timescale 1ns/1ps
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrEn,
  input  logic [31:0]        cmdWrData,
  input  logic               busy,
  input  logic [IDX_W-1:0]   bitIdx,
  input  mdioStrobes_t       strobes,
  input  logic               mdioIn,
  output logic               startReq,
  output logic [31:0]        cmdRdData,
  output logic               mdioOut,
  output logic               mdioOe,
  output logic               doneIrq,
  output logic               errIrq
);
  logic [1:0]           opField;
  logic [4:0]           phyField;
  logic [4:0]           regField;
  logic [15:0]          dataField;
  logic                 failFlag;
  logic [FRAME_LEN-1:0] txShift;
  logic [15:0]          rxShift;
  logic                 taOk;
  logic                 accept;
  logic                 isRead;
  logic                 rxPhase;

  function automatic logic [FRAME_LEN-1:0] buildFrame(input logic [31:0] w);
    logic [1:0] ta;
    ta = (w[27:26] == OP_READ) ? 2'b11 : 2'b10;
    return {{PREAMBLE_LEN{1'b1}}, 2'b01, w[27:26], w[25:21], w[20:16], ta, w[15:0]};
  endfunction

  assign accept    = cmdWrEn && !busy;
  assign startReq  = accept && cmdWrData[BIT_BUSY];
  assign isRead    = (opField == OP_READ);
  assign rxPhase   = (bitIdx >= IDX_W'(TA_FIRST));
  assign mdioOe    = busy && !(isRead && rxPhase);
  assign mdioOut   = txShift[FRAME_LEN-1];
  assign cmdRdData = {2'b00, busy, failFlag, opField, phyField, regField, dataField};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opField   <= '0;
      phyField  <= '0;
      regField  <= '0;
      dataField <= '0;
      failFlag  <= 1'b0;
      txShift   <= '1;
      rxShift   <= '0;
      taOk      <= 1'b0;
      doneIrq   <= 1'b0;
      errIrq    <= 1'b0;
    end else begin
      doneIrq <= strobes.finish;
      errIrq  <= strobes.finish && isRead && !taOk;
      if (accept) begin
        opField   <= cmdWrData[27:26];
        phyField  <= cmdWrData[25:21];
        regField  <= cmdWrData[20:16];
        dataField <= cmdWrData[15:0];
        failFlag  <= cmdWrData[BIT_BUSY] ? 1'b0 : cmdWrData[BIT_FAIL];
      end
      if (strobes.launch) begin
        txShift <= buildFrame(cmdWrData);
        taOk    <= 1'b0;
      end else if (strobes.shiftEdge) begin
        txShift <= {txShift[FRAME_LEN-2:0], 1'b1};
      end
      if (strobes.sampleEdge && isRead) begin
        if (bitIdx == IDX_W'(TA_SECOND)) taOk <= !mdioIn;
        else if (bitIdx >= IDX_W'(DATA_FIRST)) rxShift <= {rxShift[14:0], mdioIn};
      end
      if (strobes.finish && isRead) begin
        if (taOk) dataField <= rxShift;
        else      failFlag  <= 1'b1;
      end
    end
  end

  assert_fields_frozen_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable({opField, phyField, regField}));

  assert_err_with_done_R8 : assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> doneIrq);

  assert_done_on_busy_fall_R8 : assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> $fell(busy));
endmodule

// File: rtl/mdio_cmd_engine.sv
`timescale 1ns/1ps
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [31:0]       cmdWrData,
  output logic [31:0]       cmdRdData,
  input  logic [DIV_W-1:0]  mdcHalf,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn,
  output logic              doneIrq,
  output logic              errIrq
);
  logic             busy;
  logic             startReq;
  logic [IDX_W-1:0] bitIdx;
  mdioStrobes_t     strobes;

  mdio_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .mdcHalf  (mdcHalf),
    .busy     (busy),
    .mdc      (mdc),
    .bitIdx   (bitIdx),
    .strobes  (strobes)
  );

  mdio_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWrEn   (cmdWrEn),
    .cmdWrData (cmdWrData),
    .busy      (busy),
    .bitIdx    (bitIdx),
    .strobes   (strobes),
    .mdioIn    (mdioIn),
    .startReq  (startReq),
    .cmdRdData (cmdRdData),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe),
    .doneIrq   (doneIrq),
    .errIrq    (errIrq)
  );

  assert_mdio_moves_on_fall_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(mdioOut)) |-> $fell(mdc));
endmodule

// File: tb/mdio_cmd_engine_bench.sv
`timescale 1ns/1ps
module mdio_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [31:0] cmdWrData = '0;
  logic [31:0] cmdRdData;
  logic [7:0]  mdcHalf = 8'd1;
  logic        mdc, mdioOut, mdioOe, doneIrq, errIrq;
  logic        mdioIn = 1'b1;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int doneSeen = 0;
  int errSeen = 0;

  int          phyIdx = 0;
  logic [63:0] capFrame = '0;
  int          oeBad = 0;
  logic        phyRespond = 1'b0;
  logic [15:0] phyData = '0;

  always #2.5 clk = ~clk;

  mdio_cmd_engine u_mdio_cmd_engine (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdRdData(cmdRdData), .mdcHalf(mdcHalf), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn), .doneIrq(doneIrq), .errIrq(errIrq)
  );

  // PHY model: capture on MDC rise, respond on MDC fall
  always @(posedge mdc) begin
    capFrame = {capFrame[62:0], mdioOut};
    if (phyIdx >= 46 && mdioOe) oeBad = oeBad + 1;
    phyIdx = phyIdx + 1;
  end

  always @(negedge mdc) begin
    if (!phyRespond || phyIdx < 47 || phyIdx > 63) mdioIn = 1'b1;
    else if (phyIdx == 47) mdioIn = 1'b0;
    else mdioIn = phyData[63 - phyIdx];
  end

  always @(negedge clk) if (rstN) begin
    doneSeen = doneSeen + int'(doneIrq);
    errSeen  = errSeen + int'(errIrq);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles == 150000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared = compared + 1;
    if (act !== exp) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input logic start, input logic [1:0] op,
                                        input logic [4:0] phy, input logic [4:0] rg,
                                        input logic [15:0] d);
    return {2'b00, start, 1'b0, op, phy, rg, d};
  endfunction

  task automatic writeCmd(input logic [31:0] w);
    @(negedge clk);
    cmdWrEn = 1'b1;
    cmdWrData = w;
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic prepare();
    phyIdx = 0;
    oeBad = 0;
    doneSeen = 0;
    errSeen = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 5000 && cmdRdData[29]; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 word", {32'h0, cmdRdData}, 64'h0);
    check("R1 mdc/oe/irq", {60'h0, mdc, mdioOe, doneIrq, errIrq}, 64'h0);
  endtask

  task automatic testStoreOnly();
    prepare();
    writeCmd(32'hC000_0000 | mkCmd(0, 2'b01, 5'd3, 5'd9, 16'h1357) | 32'h1000_0000);
    check("R2 layout readback", {32'h0, cmdRdData},
          {32'h0, mkCmd(0, 2'b01, 5'd3, 5'd9, 16'h1357) | 32'h1000_0000});
    repeat (10) @(negedge clk);
    check("R3 no launch without start", {62'h0, mdioOe, mdc}, 64'h0);
  endtask

  task automatic testWrite();
    logic [31:0] w;
    prepare();
    phyRespond = 1'b0;
    w = mkCmd(1, 2'b01, 5'd5, 5'h12, 16'hBEEF);
    writeCmd(w);
    check("R10 launch clears fail", {62'h0, cmdRdData[29:28]}, 64'h2);
    check("R3 busy after launch", {63'h0, cmdRdData[29]}, 64'h1);
    waitIdle();
    check("R5 write frame", capFrame, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'h12, 2'b10, 16'hBEEF});
    check("R3 busy cleared, fields kept", {32'h0, cmdRdData}, {32'h0, mkCmd(0, 2'b01, 5'd5, 5'h12, 16'hBEEF)});
    check("R8 done once, no err", {32'(doneSeen), 32'(errSeen)}, {32'd1, 32'd0});
  endtask

  task automatic testRead();
    prepare();
    phyRespond = 1'b1;
    phyData = 16'h1234;
    writeCmd(mkCmd(1, 2'b10, 5'd7, 5'd3, 16'h0000));
    waitIdle();
    check("R5 read header", {18'h0, capFrame[63:18]}, {18'h0, 32'hFFFF_FFFF, 2'b01, 2'b10, 5'd7, 5'd3});
    check("R6 released in turnaround/data", 64'(oeBad), 64'd0);
    check("R7 read data", {32'h0, cmdRdData}, {32'h0, mkCmd(0, 2'b10, 5'd7, 5'd3, 16'h1234)});
    check("R8 read done", {32'(doneSeen), 32'(errSeen)}, {32'd1, 32'd0});
  endtask

  task automatic testReadFail();
    prepare();
    phyRespond = 1'b0;
    writeCmd(mkCmd(1, 2'b10, 5'd9, 5'd1, 16'h00AA));
    waitIdle();
    check("R7 fail flag, data kept", {32'h0, cmdRdData},
          {32'h0, mkCmd(0, 2'b10, 5'd9, 5'd1, 16'h00AA) | 32'h1000_0000});
    check("R8 err with done", {32'(doneSeen), 32'(errSeen)}, {32'd1, 32'd1});
  endtask

  task automatic testMdcPeriod();
    realtime t1, t2;
    prepare();
    phyRespond = 1'b0;
    mdcHalf = 8'd3;
    writeCmd(mkCmd(1, 2'b01, 5'd1, 5'd2, 16'h0F0F));
    @(posedge mdc); t1 = $realtime;
    @(posedge mdc); t2 = $realtime;
    check("R9 mdc period", 64'(int'((t2 - t1) / 5.0)), 64'd8);
    waitIdle();
    check("R9 mdc idle low", {63'h0, mdc}, 64'h0);
    mdcHalf = 8'd1;
  endtask

  task automatic testOverlap();
    logic [31:0] b;
    prepare();
    phyRespond = 1'b1;
    phyData = 16'hA5C3;
    b = mkCmd(0, 2'b01, 5'd3, 5'd4, 16'h5555);
    writeCmd(mkCmd(1, 2'b10, 5'd2, 5'd6, 16'h0000));
    for (int i = 0; i < 5000 && phyIdx < 60; i++) @(negedge clk);
    cmdWrEn = 1'b1;
    cmdWrData = b;
    @(negedge clk);
    check("R4 write ignored while busy", {32'h0, cmdRdData},
          {32'h0, mkCmd(1, 2'b10, 5'd2, 5'd6, 16'h0000)});
    for (int i = 0; i < 5000 && !doneIrq; i++) @(negedge clk);
    check("R8 done with busy clear, result kept", {32'h0, cmdRdData},
          {32'h0, mkCmd(0, 2'b10, 5'd2, 5'd6, 16'hA5C3)});
    @(negedge clk);
    cmdWrEn = 1'b0;
    check("R4 write taken after busy fell", {32'h0, cmdRdData}, {32'h0, b});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testStoreOnly();
    testWrite();
    testRead();
    testReadFail();
    testMdcPeriod();
    testOverlap();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule